// File: doc/BRIEF.md
# Secure Low-Power Real-Time Clock Core

This block keeps wall-clock time for a chip's always-on domain. A free-running slow oscillator delivers one `tick` strobe per 1/32768 s in the bus clock domain. Each strobe advances a 15-bit sub-second fraction. When the fraction wraps, a 32-bit seconds word advances. The seconds word and the fraction together form a 47-bit time value. A seconds alarm, a control word, a status word with write-one-to-clear flags, a power-glitch key register, a monotonic write counter and a general-purpose scratch word sit behind a small word-addressed write port with a combinational read mux.

The core does not count out of reset. Software must first program the glitch key. It then steps the core out of its init state and afterwards out of its non-valid state. Only in the valid state, with the run bit set, does time advance. When the seconds value first becomes equal to the alarm value, a sticky alarm flag is set. That flag drives an interrupt line and a wake line, each with its own enable bit.

Top module: `slow_rtc_core`

## Requirements
- R1: After reset the following hold:
  - seconds, fraction, alarm, control, monotonic and scratch words all read 0;
  - lifecycle state is init (status bits 13:12 = 2'b00) and the status word reads 32'h0000_0002 (glitch flag in bit 1 set, since the key register holds 0);
  - `irq` and `wakeOut` are low.
- R2: Status bit 1 is low exactly while the glitch register (word 6) holds 32'h41736166. It is high for any other value, and writing 1 to status bit 1 does not change it.
- R3: A control write (word 4) in init moves the state to non-valid (status 13:12 = 2'b01) and sets status bit 15. This happens only if the write has bit 15 (init exit) and bit 11 (non-secure access) set and the glitch flag is clear. Otherwise the state stays init.
- R4: A control write in non-valid moves the state to valid (status 13:12 = 2'b10) and sets status bit 14. This requires bits 15, 14 and 3 (run) all set. Otherwise the state stays non-valid.
- R5: The fraction advances by one on each `tick` only while the state is valid and control bit 3 is set. When the fraction wraps from 32767 to 0, the seconds word (word 0) advances by one in the same cycle.
- R6: The fraction occupies bits 31:17 of word 1 on reads and on writes. Bits 16:0 read 0 and are ignored on writes.
- R7: While control bit 8 (lock) is set, writes to words 0 and 1 are ignored.
- R8: A seconds increment from all ones to zero sets status bit 5.
- R9: Status bit 3 (alarm) is set one cycle after the seconds word first becomes equal to the alarm word (word 2). Once cleared, it is not set again while that equality persists.
- R10: `irq` is high exactly while status bit 3 and control bit 7 are both set. `wakeOut` is high exactly while status bit 3 and control bit 4 are both set.
- R11: Writing status (word 5) clears each of flag bits 3, 5, 14 and 15 where the written bit is 1 and leaves the others unchanged. Writing all ones clears every flag. The lifecycle bits are not affected.
- R12: A control write with bit 0 set does the following, and bit 0 reads back as 0:
  - returns the state to init;
  - clears all flags, the control word, the seconds word, the fraction and the alarm word;
  - keeps the glitch key, the scratch word and the monotonic counter.
- R13: Each write to word 3 increments the monotonic counter by one, whatever the data. Word 7 is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Word index of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Alarm interrupt |
| wakeOut | output | 1 | Alarm wake request |

## Verification
A wrong lifecycle state shows up at once in status bits 13:12 on the next read. It also shows up indirectly, because the fraction word stays frozen under ticks that should move it. A corrupted match history shows up one cycle after the seconds or alarm write: the alarm flag and `irq` either fail to rise or rise again after a clear. A mistake in the wrap logic is visible within two ticks of a preloaded fraction of 32766, in both the seconds word and status bit 5.

// File: rtl/slow_rtc_pkg.sv
package slow_rtc_pkg;
  parameter int DATA_W   = 32;
  parameter int SEC_W    = DATA_W;
  parameter int FRAC_W   = 15;
  parameter int FRAC_LSB = DATA_W - FRAC_W;
  parameter int ADDR_W   = 3;
  parameter int NUM_REGS = 2 ** ADDR_W;
  parameter logic [DATA_W-1:0] GLITCH_KEY = 32'h4173_6166;

  // word indexes
  parameter int A_SEC = 0, A_FRAC = 1, A_ALARM = 2, A_MONO = 3;
  parameter int A_CTRL = 4, A_STAT = 5, A_GLITCH = 6, A_GP = 7;

  // control bits
  parameter int CB_SWRST = 0, CB_RUN = 3, CB_WAKE = 4, CB_AIE = 7;
  parameter int CB_LOCK = 8, CB_NSA = 11, CB_NVX = 14, CB_INX = 15;
  parameter logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << CB_RUN) | (DATA_W'(1) << CB_WAKE) | (DATA_W'(1) << CB_AIE) |
    (DATA_W'(1) << CB_LOCK) | (DATA_W'(1) << CB_NSA) | (DATA_W'(1) << CB_NVX) |
    (DATA_W'(1) << CB_INX);

  // status bits
  parameter int SB_PGD = 1, SB_ALM = 3, SB_ROLL = 5, SB_STLO = 12, SB_NVX = 14, SB_INX = 15;

  typedef enum logic [1:0] {
    LC_INIT     = 2'b00,
    LC_NONVALID = 2'b01,
    LC_VALID    = 2'b10
  } lifeState_t;

  typedef struct packed {
    logic              secWr;
    logic              fracWr;
    logic              alarmWr;
    logic              countEn;
    logic              swReset;
    logic [DATA_W-1:0] data;
  } dpCmd_t;
endpackage

// File: rtl/slow_rtc_datapath.sv
module slow_rtc_datapath
  import slow_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  output logic [SEC_W-1:0]  secCnt,
  output logic [FRAC_W-1:0] fracCnt,
  output logic [SEC_W-1:0]  alarmVal,
  output logic              matchRise,
  output logic              rollPulse
);
  localparam logic [FRAC_W-1:0] FRAC_MAX = {FRAC_W{1'b1}};

  logic matchPrev;
  logic matchNow;
  logic fracWrap;

  assign fracWrap  = cmd.countEn && !cmd.fracWr && (fracCnt == FRAC_MAX);
  assign rollPulse = fracWrap && !cmd.secWr && (&secCnt);
  assign matchNow  = (secCnt == alarmVal);
  assign matchRise = matchNow && !matchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCnt    <= '0;
      fracCnt   <= '0;
      alarmVal  <= '0;
      matchPrev <= 1'b1;
    end else if (cmd.swReset) begin
      secCnt    <= '0;
      fracCnt   <= '0;
      alarmVal  <= '0;
      matchPrev <= 1'b1;
    end else begin
      if (cmd.fracWr)       fracCnt <= cmd.data[DATA_W-1:FRAC_LSB];
      else if (cmd.countEn) fracCnt <= fracCnt + 1'b1;

      if (cmd.secWr)        secCnt <= cmd.data[SEC_W-1:0];
      else if (fracWrap)    secCnt <= secCnt + 1'b1;

      if (cmd.alarmWr)      alarmVal <= cmd.data[SEC_W-1:0];

      matchPrev <= matchNow;
    end
  end

  // R5
  frac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.countEn && !cmd.fracWr && !cmd.swReset) |=> $stable(fracCnt));

  // R5
  sec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.countEn && !cmd.fracWr && !cmd.secWr && !cmd.swReset && fracCnt == FRAC_MAX)
      |=> (secCnt == $past(secCnt) + 1'b1) && (fracCnt == '0));
endmodule

// File: rtl/slow_rtc_control.sv
module slow_rtc_control
  import slow_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEC_W-1:0]  secCnt,
  input  logic [FRAC_W-1:0] fracCnt,
  input  logic [SEC_W-1:0]  alarmVal,
  input  logic              matchRise,
  input  logic              rollPulse,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wakeOut
);
  logic [DATA_W-1:0]   ctrlReg;
  logic [DATA_W-1:0]   glitchReg;
  logic [DATA_W-1:0]   gpReg;
  logic [DATA_W-1:0]   monoCnt;
  lifeState_t          lifeState;
  logic                alarmFlag, rollFlag, nvxFlag, inxFlag;
  logic [NUM_REGS-1:0] wrSel;
  logic                glitchOk;
  logic                ctrlWrite;
  logic                swRst;
  logic [DATA_W-1:0]   statusWord;

  always_comb begin
    wrSel = '0;
    if (wrEn) wrSel[addr] = 1'b1;
  end

  assign glitchOk  = (glitchReg == GLITCH_KEY);
  assign ctrlWrite = wrSel[A_CTRL];
  assign swRst     = ctrlWrite && wrData[CB_SWRST];

  always_comb begin
    cmd.secWr   = wrSel[A_SEC]  && !ctrlReg[CB_LOCK];
    cmd.fracWr  = wrSel[A_FRAC] && !ctrlReg[CB_LOCK];
    cmd.alarmWr = wrSel[A_ALARM];
    cmd.countEn = tick && (lifeState == LC_VALID) && ctrlReg[CB_RUN];
    cmd.swReset = swRst;
    cmd.data    = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      glitchReg <= '0;
      gpReg     <= '0;
      monoCnt   <= '0;
      lifeState <= LC_INIT;
      alarmFlag <= 1'b0;
      rollFlag  <= 1'b0;
      nvxFlag   <= 1'b0;
      inxFlag   <= 1'b0;
    end else begin
      if (wrSel[A_GLITCH]) glitchReg <= wrData;
      if (wrSel[A_GP])     gpReg     <= wrData;
      if (wrSel[A_MONO])   monoCnt   <= monoCnt + 1'b1;

      if (swRst) begin
        ctrlReg   <= '0;
        lifeState <= LC_INIT;
        alarmFlag <= 1'b0;
        rollFlag  <= 1'b0;
        nvxFlag   <= 1'b0;
        inxFlag   <= 1'b0;
      end else begin
        if (ctrlWrite) begin
          ctrlReg <= wrData & CTRL_MASK;
          case (lifeState)
            LC_INIT:
              if (wrData[CB_INX] && wrData[CB_NSA] && glitchOk) begin
                lifeState <= LC_NONVALID;
                inxFlag   <= 1'b1;
              end
            LC_NONVALID:
              if (wrData[CB_INX] && wrData[CB_NVX] && wrData[CB_RUN]) begin
                lifeState <= LC_VALID;
                nvxFlag   <= 1'b1;
              end
            default: ;
          endcase
        end
        if (wrSel[A_STAT]) begin
          if (wrData[SB_ALM])  alarmFlag <= 1'b0;
          if (wrData[SB_ROLL]) rollFlag  <= 1'b0;
          if (wrData[SB_NVX])  nvxFlag   <= 1'b0;
          if (wrData[SB_INX])  inxFlag   <= 1'b0;
        end
        if (matchRise) alarmFlag <= 1'b1;
        if (rollPulse) rollFlag  <= 1'b1;
      end
    end
  end

  always_comb begin
    statusWord              = '0;
    statusWord[SB_PGD]      = !glitchOk;
    statusWord[SB_ALM]      = alarmFlag;
    statusWord[SB_ROLL]     = rollFlag;
    statusWord[SB_STLO+:2]  = lifeState;
    statusWord[SB_NVX]      = nvxFlag;
    statusWord[SB_INX]      = inxFlag;
  end

  always_comb begin
    case (addr)
      ADDR_W'(A_SEC):    rdData = secCnt;
      ADDR_W'(A_FRAC):   rdData = {fracCnt, {FRAC_LSB{1'b0}}};
      ADDR_W'(A_ALARM):  rdData = alarmVal;
      ADDR_W'(A_MONO):   rdData = monoCnt;
      ADDR_W'(A_CTRL):   rdData = ctrlReg;
      ADDR_W'(A_STAT):   rdData = statusWord;
      ADDR_W'(A_GLITCH): rdData = glitchReg;
      default:           rdData = gpReg;
    endcase
  end

  assign irq     = alarmFlag && ctrlReg[CB_AIE];
  assign wakeOut = alarmFlag && ctrlReg[CB_WAKE];

  // R3
  init_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lifeState) == LC_INIT && lifeState == LC_NONVALID) |-> $past(glitchOk));

  // R4
  valid_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lifeState == LC_VALID && $past(lifeState) != LC_VALID) |-> ($past(lifeState) == LC_NONVALID));

  // R9
  alarm_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(matchRise));

  // R12
  swreset_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.swReset |=> (lifeState == LC_INIT) && !alarmFlag && (ctrlReg == '0));
endmodule

// File: rtl/slow_rtc_core.sv
module slow_rtc_core
  import slow_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wakeOut
);
  dpCmd_t            cmd;
  logic [SEC_W-1:0]  secCnt;
  logic [FRAC_W-1:0] fracCnt;
  logic [SEC_W-1:0]  alarmVal;
  logic              matchRise;
  logic              rollPulse;

  slow_rtc_control u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .secCnt(secCnt), .fracCnt(fracCnt), .alarmVal(alarmVal),
    .matchRise(matchRise), .rollPulse(rollPulse),
    .cmd(cmd), .rdData(rdData), .irq(irq), .wakeOut(wakeOut)
  );

  slow_rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .secCnt(secCnt), .fracCnt(fracCnt), .alarmVal(alarmVal),
    .matchRise(matchRise), .rollPulse(rollPulse)
  );
endmodule

// File: tb/test_slow_rtc_core.sv
module test_slow_rtc_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq, wakeOut;

  int checks = 0;
  int errors = 0;

  slow_rtc_core i_slow_rtc_core (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wakeOut(wakeOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd5, v); check("R1 status", v, 32'h0000_0002);
    rd(3'd0, v); check("R1 seconds", v, 32'h0);
    rd(3'd4, v); check("R1 control", v, 32'h0);
    check("R1 irq/wake", {30'd0, irq, wakeOut}, 32'h0);
  endtask

  task automatic t_lifecycle;
    logic [31:0] v;
    wr(3'd4, 32'h0000_8800);
    rd(3'd5, v); check("R3 blocked by glitch flag", v, 32'h0000_0002);
    wr(3'd6, 32'h1234_5678);
    rd(3'd5, v); check("R2 wrong key", v, 32'h0000_0002);
    wr(3'd5, 32'h0000_0002);
    rd(3'd5, v); check("R2 w1c ignored", v, 32'h0000_0002);
    wr(3'd6, 32'h4173_6166);
    rd(3'd5, v); check("R2 key accepted", v, 32'h0);
    wr(3'd4, 32'h0000_8000);
    rd(3'd5, v); check("R3 needs non-secure bit", v, 32'h0);
    wr(3'd4, 32'h0000_8800);
    rd(3'd5, v); check("R3 init exit", v, 32'h0000_9000);
    wr(3'd4, 32'h0000_8808);
    ticks(5);
    rd(3'd1, v); check("R5 no count in non-valid", v, 32'h0);
    wr(3'd4, 32'h0000_C800);
    rd(3'd5, v); check("R4 needs run bit", v, 32'h0000_9000);
    wr(3'd4, 32'h0000_C808);
    rd(3'd5, v); check("R4 valid entry", v, 32'h0000_E000);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(3'd2, 32'h0000_7777);
    ticks(5);
    rd(3'd1, v); check("R6 fraction position", v, 32'h000A_0000);
    wr(3'd1, 32'hFFFC_0000);
    ticks(2);
    rd(3'd0, v); check("R5 seconds carry", v, 32'h1);
    rd(3'd1, v); check("R5 fraction wrap", v, 32'h0);
    wr(3'd1, 32'hFFFD_FFFF);
    rd(3'd1, v); check("R6 low bits ignored", v, 32'hFFFC_0000);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(3'd4, 32'h0000_C908);
    wr(3'd0, 32'h0000_0055);
    rd(3'd0, v); check("R7 seconds locked", v, 32'h1);
    wr(3'd1, 32'h0);
    rd(3'd1, v); check("R7 fraction locked", v, 32'hFFFC_0000);
    wr(3'd4, 32'h0000_C808);
  endtask

  task automatic t_rollover;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFE_0000);
    ticks(1);
    rd(3'd0, v); check("R8 seconds wrap", v, 32'h0);
    rd(3'd5, v); check("R8 rollover flag", v, 32'h0000_E020);
    wr(3'd5, 32'h0000_0020);
    rd(3'd5, v); check("R11 clear rollover", v, 32'h0000_E000);
  endtask

  task automatic t_alarm;
    logic [31:0] v;
    wr(3'd4, 32'h0000_C898);
    wr(3'd2, 32'd10);
    wr(3'd0, 32'd9);
    wr(3'd1, 32'hFFFE_0000);
    check("R10 irq before match", {31'd0, irq}, 32'h0);
    ticks(1);
    @(negedge clk);
    check("R9 irq and wake", {30'd0, irq, wakeOut}, 32'h3);
    rd(3'd5, v); check("R9 alarm flag", v, 32'h0000_E008);
    wr(3'd5, 32'h0000_0008);
    repeat (3) @(negedge clk);
    rd(3'd5, v); check("R9 no re-set while equal", v, 32'h0000_E000);
    check("R9 irq low after clear", {31'd0, irq}, 32'h0);
    wr(3'd4, 32'h0000_C818);
    wr(3'd2, 32'd11);
    wr(3'd0, 32'd11);
    @(negedge clk);
    check("R10 interrupt disabled, wake on", {30'd0, irq, wakeOut}, 32'h1);
    rd(3'd5, v); check("R9 second match", v, 32'h0000_E008);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(3'd5, 32'h0000_4000);
    rd(3'd5, v); check("R11 single bit clear", v, 32'h0000_A008);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); check("R11 clear all", v, 32'h0000_2000);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    rd(3'd3, v); check("R13 monotonic start", v, 32'h0);
    wr(3'd3, 32'hDEAD_BEEF);
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R13 monotonic count", v, 32'h2);
    wr(3'd7, 32'h0000_A5A5);
    rd(3'd7, v); check("R13 scratch", v, 32'h0000_A5A5);
  endtask

  task automatic t_swreset;
    logic [31:0] v;
    wr(3'd4, 32'h0000_0001);
    rd(3'd5, v); check("R12 status", v, 32'h0);
    rd(3'd4, v); check("R12 control", v, 32'h0);
    rd(3'd0, v); check("R12 seconds", v, 32'h0);
    rd(3'd2, v); check("R12 alarm", v, 32'h0);
    rd(3'd7, v); check("R12 scratch kept", v, 32'h0000_A5A5);
    rd(3'd3, v); check("R12 monotonic kept", v, 32'h2);
    ticks(3);
    rd(3'd1, v); check("R12 no count in init", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lifecycle();
    t_count();
    t_lock();
    t_rollover();
    t_alarm();
    t_w1c();
    t_misc();
    t_swreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule